// File: doc/BRIEF.md
# Write-Command Word Packer

This block sits between a 16-bit write port on the processor side and a 32-bit command port on a memory controller. Both run on one clock. Each write command arrives as three 16-bit halves. The first two halves build the 32-bit address word (bank, row and column), and the third half is the write payload. Once all three halves are in, the block sends two 32-bit beats with no gap between them: first the address word, then the data word with the payload in its low half.

A toggle flop chooses which half of the address register receives the next accepted address half. A small state machine moves through four phases: address collection, payload collection, address beat and data beat. The output uses a valid/ready handshake. The controller may wait many cycles before it takes the address beat. It must accept the data beat in the cycle that follows. While a command is being sent, the input ready signal is held low, so the producer is stalled and no half is lost.

Top module: `cmd_packer`

## Requirements
- R1: After synchronous reset, `out_valid` is 0 and `in_ready` is 1, and the next accepted half is routed to the upper address half, even when reset arrived part way through a command.
- R2: The first accepted half of a command becomes bits [31:16] of the address beat. The second accepted half becomes bits [15:0]. A half is accepted on a rising edge where `in_valid` and `in_ready` are both 1.
- R3: The third accepted half is the payload. The data beat carries it in bits [15:0], and bits [31:16] are 0.
- R4: From the cycle after the third half is accepted until the data beat has been sent, `in_ready` is 0. Any `in_valid` asserted in that window is ignored.
- R5: The address beat is shown with `out_valid`=1 and `out_is_data`=0. It stays stable for as long as `out_ready` is 0 (tested up to 15 cycles).
- R6: The data beat (`out_valid`=1, `out_is_data`=1) appears in the cycle right after the edge on which the address beat is accepted.
- R7: The data beat lasts one cycle. In the next cycle `out_valid` is 0 and `in_ready` is 1.
- R8: Idle cycles with `in_valid`=0 between halves have no effect on the words that are assembled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input half is present |
| in_ready | output | 1 | Block can accept a half |
| in_data | input | 16 | Input half |
| out_valid | output | 1 | Output beat is present |
| out_ready | input | 1 | Controller takes the beat |
| out_is_data | output | 1 | 0 = address beat, 1 = data beat |
| out_data | output | 32 | Output beat |

## Verification
The assertions check the output-side protocol on every cycle. They cover the address beat holding steady under back-pressure, the data beat following an accepted address with no gap, the data beat's zero upper half, the one-cycle data beat with input reopening after it, and input being closed whenever output is valid. Only the bench scenarios can show that the right halves end up in the right fields. The same goes for ignoring junk input offered while the block is busy, for tolerating idle gaps, and for a reset in mid-command restarting at the upper half.

// File: rtl/cmd_packer.sv
module cmd_packer #(
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [HALF_W-1:0]   in_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic                out_is_data,
  output logic [2*HALF_W-1:0] out_data
);
  localparam int WORD_W = 2 * HALF_W;

  typedef enum logic [1:0] {GET_ADDR, GET_DATA, PUT_ADDR, PUT_DATA} phase_t;

  phase_t              phase;
  logic                hi_lo_sel;
  logic [WORD_W-1:0]   addr_q;
  logic [HALF_W-1:0]   data_q;
  logic                take;

  assign in_ready    = (phase == GET_ADDR) || (phase == GET_DATA);
  assign take        = in_valid && in_ready;
  assign out_valid   = (phase == PUT_ADDR) || (phase == PUT_DATA);
  assign out_is_data = (phase == PUT_DATA);
  assign out_data    = out_is_data ? {{HALF_W{1'b0}}, data_q} : addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= GET_ADDR;
      hi_lo_sel <= 1'b0;
      addr_q    <= '0;
      data_q    <= '0;
    end else begin
      case (phase)
        GET_ADDR: if (take) begin
          if (!hi_lo_sel) addr_q[WORD_W-1:HALF_W] <= in_data;
          else begin
            addr_q[HALF_W-1:0] <= in_data;
            phase <= GET_DATA;
          end
          hi_lo_sel <= ~hi_lo_sel;
        end
        GET_DATA: if (take) begin
          data_q <= in_data;
          phase  <= PUT_ADDR;
        end
        PUT_ADDR: if (out_ready) phase <= PUT_DATA;
        default:  phase <= GET_ADDR;
      endcase
    end
  end

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_is_data && !out_ready |=> out_valid && !out_is_data && $stable(out_data)); // R5
  AST_DATA_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_is_data && out_ready |=> out_valid && out_is_data); // R6
  AST_DATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_is_data |-> out_data[WORD_W-1:HALF_W] == '0); // R3
  AST_INPUT_CLOSED: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready); // R4
  AST_DATA_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_is_data |=> !out_valid && in_ready); // R7
endmodule

// File: tb/test_cmd_packer.sv
module test_cmd_packer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic        out_is_data;
  logic [31:0] out_data;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  cmd_packer i_cmd_packer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_is_data(out_is_data), .out_data(out_data)
  );

  function automatic logic [31:0] exp_addr(input logic [15:0] hi, input logic [15:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic [31:0] exp_payload(input logic [15:0] d);
    return {16'h0000, d};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_half(input logic [15:0] h, input int gap);
    for (int i = 0; i < gap; i++) begin
      in_valid = 1'b0;
      in_data  = 16'($urandom);
      @(negedge clk);
    end
    check("R8 in_ready before half", 32'(in_ready), 32'd1);
    in_valid = 1'b1;
    in_data  = h;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_cmd(input logic [15:0] hi, input logic [15:0] lo,
                         input logic [15:0] d, input int max_gap, input int stall);
    send_half(hi, $urandom_range(max_gap));
    send_half(lo, $urandom_range(max_gap));
    send_half(d,  $urandom_range(max_gap));
    for (int i = 0; i <= stall; i++) begin
      check("R5 address beat valid", {out_valid, out_is_data}, 32'b10);
      check("R2 address word", out_data, exp_addr(hi, lo));
      check("R4 in_ready low", 32'(in_ready), 32'd0);
      in_valid  = 1'b1;
      in_data   = 16'($urandom);
      out_ready = (i == stall);
      @(negedge clk);
    end
    check("R6 data beat follows", {out_valid, out_is_data}, 32'b11);
    check("R3 data word", out_data, exp_payload(d));
    check("R4 in_ready low on data beat", 32'(in_ready), 32'd0);
    out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 idle after data beat", {out_valid, in_ready}, 32'b01);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset out_valid", 32'(out_valid), 32'd0);
    check("R1 reset in_ready", 32'(in_ready), 32'd1);

    run_cmd(16'hFFFF, 16'h0000, 16'hFFFF, 0, 0);
    run_cmd(16'h1234, 16'h5678, 16'h9ABC, 0, 15);
    run_cmd(16'h0001, 16'h8000, 16'hA5A5, 4, 3);

    send_half(16'hDEAD, 0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 mid-command reset out_valid", 32'(out_valid), 32'd0);
    check("R1 mid-command reset in_ready", 32'(in_ready), 32'd1);
    run_cmd(16'hC0DE, 16'hBEEF, 16'h0F0F, 0, 1);

    for (int n = 0; n < 40; n++)
      run_cmd(16'($urandom), 16'($urandom), 16'($urandom), 5, $urandom_range(15));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule